// File: doc/BRIEF.md
# Serial Channel Status Register

This block is the 16-bit status register of one serial channel, together with the formatting logic for that channel's receive data reads. The lower byte always shows present conditions. These are the three modem inputs, the two transmit-empty indications and receive-data-available. None of them is stored. The upper byte holds the receive event flags, which stay set once raised, and a control bit that selects the receive read format.

Software reads the whole word to collect and clear the event flags. It reads only the lower byte to poll the line state without losing events. With the format bit set, a word read of the receive data port returns one character together with its error bits. With the bit clear, the same read returns two characters. The receiver and the FIFO are outside the block. They supply one-cycle event pulses, the level inputs, and the next two characters and their error bits.

Host reads are combinational: `hst_rdata` is valid in the cycle `hst_rd` is high. Any clear or mode change takes effect at the following clock edge.

Top module: `chan_status_reg`

## Requirements
- R1: During a status read, bits 5..0 of `hst_rdata` show the live inputs in the same cycle: bit 5 `cts_in`, bit 4 `dsr_in`, bit 3 `cd_in`, bit 2 `txf_empty`, bit 1 `txsh_empty`, bit 0 `rx_avail`. Bits 7..6 read zero.
- R2: A one-cycle pulse on an event input sets its sticky flag from the next cycle on. The flag positions are bit 13 overflow, bit 12 compare-2 match, bit 11 compare-1 match, bit 10 break, bit 9 framing and bit 8 parity. Bit 15 is the format bit and bit 14 reads zero.
- R3: A word read of the status register (`hst_rx_sel`=0, `hst_word`=1) returns the current flags and clears every event flag at the next edge.
- R4: A low-byte read of the status register (`hst_word`=0) returns {8'h00, live byte} and leaves every event flag unchanged.
- R5: An event pulse that arrives in the same cycle as a clearing word read is kept set after that edge.
- R6: A word write to the status register loads the format bit from `hst_wdata[15]` and ignores every other bit. 0x8000 enables the format and 0x0000 disables it. A low-byte write and all reads leave the format bit unchanged.
- R7: With the format bit set, a word read of the receive port returns {4'h0, `rx_err0`, `rx_char0`}. The error byte has bit 3 break, bit 2 framing, bit 1 overrun and bit 0 parity.
- R8: With the format bit clear, a word read of the receive port returns {`rx_char1`, `rx_char0`}.
- R9: A low-byte read of the receive port returns {8'h00, `rx_char0`} in either format.
- R10: `tx_drained` is high exactly when both `txf_empty` and `txsh_empty` are high.
- R11: After reset, the format bit and all event flags are zero.
- R12: While `hst_rd` is low, `hst_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_word | input | 1 | 1 = 16-bit access, 0 = low byte only |
| hst_rx_sel | input | 1 | 0 = status register, 1 = receive data port |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid in the cycle of `hst_rd` |
| cts_in | input | 1 | Clear-to-send level |
| dsr_in | input | 1 | Data-set-ready level |
| cd_in | input | 1 | Carrier-detect level |
| txf_empty | input | 1 | Transmit FIFO empty |
| txsh_empty | input | 1 | Transmit shift register empty |
| rx_avail | input | 1 | Receive data available |
| ev_ovf | input | 1 | Pulse: receive FIFO overflow |
| ev_cmp2 | input | 1 | Pulse: compare-2 match |
| ev_cmp1 | input | 1 | Pulse: compare-1 match |
| ev_break | input | 1 | Pulse: break received |
| ev_frame | input | 1 | Pulse: framing error |
| ev_parity | input | 1 | Pulse: parity error |
| rx_char0 | input | 8 | Next receive character |
| rx_char1 | input | 8 | Character after that |
| rx_err0 | input | 4 | Error bits of `rx_char0` |
| tx_drained | output | 1 | Transmit path fully empty |

## Verification
Two things can land on the same clock edge. One is an incoming receive event, the other a clearing word read of the status register. A format write can also coincide with a read of either port. The bench provokes both by directed cycles that pulse an event during a word read, and by random traffic that mixes sparse events with reads and writes. A reference model applies the rule that an arriving event beats the clear and a read returns the pre-edge value. Each outcome is judged by a later word read, which must show the kept flag while the earlier flags are gone.

// File: rtl/csr_pkg.sv
// Package: shared widths and bit positions of the channel status register.
// Assumes an 8-bit character and a 16-bit host word.
package csr_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int EVT_W    = 6;   // overflow, cmp2, cmp1, break, framing, parity
    localparam int LIVE_W   = 6;   // cts, dsr, cd, txf empty, txsh empty, rx avail
    localparam int CHERR_W  = 4;   // break, framing, overrun, parity
    localparam int MODE_BIT = 15;
    localparam int EVT_LSB  = 8;

    typedef enum logic [1:0] {
        ACC_STAT_BYTE = 2'b00,
        ACC_STAT_WORD = 2'b01,
        ACC_RX_BYTE   = 2'b10,
        ACC_RX_WORD   = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/csr_sticky_bank.sv
// Module: bank of sticky event flags.
// Each flag sets on a one-cycle pulse and clears on clr_i; a pulse in the
// same cycle as clr_i wins. Assumes pulses are synchronous to clk.
module csr_sticky_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic q;
        // Hold, clear or set one flag; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (evt_i[g]) q <= 1'b1;
            else if (clr_i)    q <= 1'b0;
        end
        assign flags_o[g] = q;
    end
endmodule

// File: rtl/csr_mode_ctl.sv
// Module: receive-format control bit.
// Changes only on an explicit load strobe; reads never touch it.
module csr_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic val_i,
    output logic mode_o
);
    // Load the format bit on a qualified host write.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_o <= 1'b0;
        else if (load_i) mode_o <= val_i;
    end
endmodule

// File: rtl/csr_rx_format.sv
// Module: builds the host view of receive data.
// Word access: either two characters or one character plus its error bits,
// chosen by mode_i. Byte access: the first character only. Purely combinational.
module csr_rx_format #(
    parameter int BYTE_W = 8,
    parameter int ERR_W  = 4
) (
    input  logic                mode_i,
    input  logic                word_i,
    input  logic [BYTE_W-1:0]   char0_i,
    input  logic [BYTE_W-1:0]   char1_i,
    input  logic [ERR_W-1:0]    err0_i,
    output logic [2*BYTE_W-1:0] data_o
);
    localparam int PAD_W = BYTE_W - ERR_W;

    // Select the upper half according to access size and format.
    always_comb begin
        if (!word_i)     data_o = {{BYTE_W{1'b0}}, char0_i};
        else if (mode_i) data_o = {{PAD_W{1'b0}}, err0_i, char0_i};
        else             data_o = {char1_i, char0_i};
    end
endmodule

// File: rtl/chan_status_reg.sv
// Module: per-channel status register with clear-on-word-read event flags,
// a receive-format bit and the receive data formatter.
// Assumes host strobes last one cycle and read data is taken in that cycle.
module chan_status_reg
    import csr_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int ERR_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hst_rd,
    input  logic                hst_wr,
    input  logic                hst_word,
    input  logic                hst_rx_sel,
    input  logic [15:0]         hst_wdata,
    output logic [15:0]         hst_rdata,
    input  logic                cts_in,
    input  logic                dsr_in,
    input  logic                cd_in,
    input  logic                txf_empty,
    input  logic                txsh_empty,
    input  logic                rx_avail,
    input  logic                ev_ovf,
    input  logic                ev_cmp2,
    input  logic                ev_cmp1,
    input  logic                ev_break,
    input  logic                ev_frame,
    input  logic                ev_parity,
    input  logic [CHAR_W-1:0]   rx_char0,
    input  logic [CHAR_W-1:0]   rx_char1,
    input  logic [ERR_W-1:0]    rx_err0,
    output logic                tx_drained
);
    localparam int PAD_LO = BYTE_W - LIVE_W;

    acc_kind_e          acc;
    logic               stat_word_rd;
    logic               stat_byte_rd;
    logic               mode_wr;
    logic               mode;
    logic [EVT_W-1:0]   evt;
    logic [EVT_W-1:0]   flags;
    logic [LIVE_W-1:0]  live;
    logic [15:0]        stat_word;
    logic [15:0]        rx_word;

    // Classify the host access by target and size.
    assign acc          = acc_kind_e'({hst_rx_sel, hst_word});
    assign stat_word_rd = hst_rd && (acc == ACC_STAT_WORD);
    assign stat_byte_rd = hst_rd && (acc == ACC_STAT_BYTE);
    assign mode_wr      = hst_wr && (acc == ACC_STAT_WORD);

    // Gather event pulses and live levels in register bit order.
    assign evt  = {ev_ovf, ev_cmp2, ev_cmp1, ev_break, ev_frame, ev_parity};
    assign live = {cts_in, dsr_in, cd_in, txf_empty, txsh_empty, rx_avail};

    csr_sticky_bank #(.N(EVT_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .clr_i   (stat_word_rd),
        .flags_o (flags)
    );

    csr_mode_ctl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mode_wr),
        .val_i  (hst_wdata[MODE_BIT]),
        .mode_o (mode)
    );

    csr_rx_format #(.BYTE_W(CHAR_W), .ERR_W(ERR_W)) u_rxfmt (
        .mode_i  (mode),
        .word_i  (hst_word),
        .char0_i (rx_char0),
        .char1_i (rx_char1),
        .err0_i  (rx_err0),
        .data_o  (rx_word)
    );

    // Assemble the full status word: format bit, zero, flags, live byte.
    assign stat_word = {mode, 1'b0, flags, {PAD_LO{1'b0}}, live};

    // Drive read data only while a read strobe is present.
    always_comb begin
        hst_rdata = '0;
        if (hst_rd) begin
            unique case (acc)
                ACC_STAT_WORD: hst_rdata = stat_word;
                ACC_STAT_BYTE: hst_rdata = {8'h00, stat_word[7:0]};
                default:       hst_rdata = rx_word;
            endcase
        end
    end

    // Transmit path is empty only when both stages are empty.
    assign tx_drained = txf_empty & txsh_empty;
endmodule

// File: rtl/csr_checker.sv
// Module: temporal checks for chan_status_reg, attached by bind.
module csr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        hst_rd,
    input logic        hst_word,
    input logic        hst_rx_sel,
    input logic [15:0] hst_rdata,
    input logic        txf_empty,
    input logic        txsh_empty,
    input logic        tx_drained,
    input logic        stat_word_rd,
    input logic        stat_byte_rd,
    input logic        mode_wr,
    input logic        mode,
    input logic [5:0]  evt,
    input logic [5:0]  flags
);
    AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags & $past(evt)) == $past(evt))); // R2
    AST_WORD_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word_rd && !(|evt)) |=> (flags == 6'd0)); // R3
    AST_BYTE_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte_rd |=> ((flags & $past(flags)) == $past(flags))); // R4
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word_rd && (|evt)) |=> (flags == $past(evt))); // R5
    AST_MODE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode)); // R6
    AST_RX_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && hst_rx_sel && hst_word && mode) |-> (hst_rdata[15:12] == 4'h0)); // R7
    AST_BYTE_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && !hst_word) |-> (hst_rdata[15:8] == 8'h00)); // R9
    AST_DRAINED_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drained |-> (txf_empty && txsh_empty)); // R10
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_rd |-> (hst_rdata == 16'h0000)); // R12
endmodule

bind chan_status_reg csr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hst_rd       (hst_rd),
    .hst_word     (hst_word),
    .hst_rx_sel   (hst_rx_sel),
    .hst_rdata    (hst_rdata),
    .txf_empty    (txf_empty),
    .txsh_empty   (txsh_empty),
    .tx_drained   (tx_drained),
    .stat_word_rd (stat_word_rd),
    .stat_byte_rd (stat_byte_rd),
    .mode_wr      (mode_wr),
    .mode         (mode),
    .evt          (evt),
    .flags        (flags)
);

// File: tb/chan_status_reg_tb.sv
module chan_status_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_rd = 0, hst_wr = 0, hst_word = 0, hst_rx_sel = 0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        cts_in = 0, dsr_in = 0, cd_in = 0;
    logic        txf_empty = 0, txsh_empty = 0, rx_avail = 0;
    logic [5:0]  ev = '0;   // {ovf, cmp2, cmp1, break, frame, parity}
    logic [7:0]  rx_char0 = '0, rx_char1 = '0;
    logic [3:0]  rx_err0 = '0;
    logic        tx_drained;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;
    logic [5:0]  m_flags = '0;
    logic        m_mode  = 1'b0;

    always #4 clk = ~clk;

    chan_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_wr(hst_wr),
        .hst_word(hst_word), .hst_rx_sel(hst_rx_sel), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .cts_in(cts_in), .dsr_in(dsr_in), .cd_in(cd_in),
        .txf_empty(txf_empty), .txsh_empty(txsh_empty), .rx_avail(rx_avail),
        .ev_ovf(ev[5]), .ev_cmp2(ev[4]), .ev_cmp1(ev[3]), .ev_break(ev[2]),
        .ev_frame(ev[1]), .ev_parity(ev[0]), .rx_char0(rx_char0),
        .rx_char1(rx_char1), .rx_err0(rx_err0), .tx_drained(tx_drained)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] live_byte();
        return {2'b00, cts_in, dsr_in, cd_in, txf_empty, txsh_empty, rx_avail};
    endfunction

    function automatic logic [15:0] exp_rdata();
        if (!hst_rd)                  return 16'h0000;
        if (!hst_word)                return {8'h00, hst_rx_sel ? rx_char0 : live_byte()};
        if (!hst_rx_sel)              return {m_mode, 1'b0, m_flags, live_byte()};
        if (m_mode)                   return {4'h0, rx_err0, rx_char0};
        return {rx_char1, rx_char0};
    endfunction

    function automatic string auto_tag();
        if (!hst_rd)     return "R12";
        if (!hst_rx_sel) return hst_word ? "R3" : "R4";
        if (!hst_word)   return "R9";
        return m_mode ? "R7" : "R8";
    endfunction

    // Called just after a negedge with inputs driven: check, step edge, update model.
    task automatic do_cycle();
        #1;
        check(auto_tag(), hst_rdata, exp_rdata());
        check("R10", {15'd0, tx_drained}, {15'd0, txf_empty & txsh_empty});
        @(posedge clk);
        if (hst_wr && !hst_rx_sel && hst_word) m_mode = hst_wdata[15];
        m_flags = ((hst_rd && !hst_rx_sel && hst_word) ? 6'd0 : m_flags) | ev;
        @(negedge clk);
    endtask

    task automatic set_acc(input logic rd, input logic wr, input logic word,
                           input logic rxs, input logic [15:0] wd, input logic [5:0] e);
        hst_rd = rd; hst_wr = wr; hst_word = word; hst_rx_sel = rxs;
        hst_wdata = wd; ev = e;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state seen through a word read with all levels low
        set_acc(1, 0, 1, 0, 16'h0, 6'h0);
        #1 check("R11", hst_rdata, 16'h0000);
        do_cycle();

        // R1: live bits pass through in the read cycle
        {cts_in, dsr_in, cd_in, txf_empty, txsh_empty, rx_avail} = 6'b101101;
        set_acc(1, 0, 0, 0, 16'h0, 6'h0);
        #1 check("R1", hst_rdata, 16'h002D);
        do_cycle();

        // R2: parity pulse, then low-byte read keeps it (R4), word read shows bit 8
        set_acc(0, 0, 0, 0, 16'h0, 6'h01);
        do_cycle();
        set_acc(1, 0, 0, 0, 16'h0, 6'h00);
        do_cycle();
        set_acc(1, 0, 1, 0, 16'h0, 6'h00);
        #1 check("R2", hst_rdata & 16'hFF00, 16'h0100);
        do_cycle();
        // R3: flags gone after the clearing read
        set_acc(1, 0, 1, 0, 16'h0, 6'h00);
        #1 check("R3", hst_rdata & 16'hFF00, 16'h0000);
        do_cycle();

        // R5: overflow pulse coincides with clearing read of an earlier break flag
        set_acc(0, 0, 0, 0, 16'h0, 6'h04);
        do_cycle();
        set_acc(1, 0, 1, 0, 16'h0, 6'h20);
        #1 check("R5", hst_rdata & 16'hFF00, 16'h0400);
        do_cycle();
        set_acc(1, 0, 1, 0, 16'h0, 6'h00);
        #1 check("R5", hst_rdata & 16'hFF00, 16'h2000);
        do_cycle();

        // R6: other bits ignored; 0x8000 enables; byte write and reads leave it
        set_acc(0, 1, 1, 0, 16'h7FFF, 6'h0);
        do_cycle();
        set_acc(1, 0, 1, 0, 16'h0, 6'h0);
        #1 check("R6", hst_rdata & 16'h8000, 16'h0000);
        do_cycle();
        set_acc(0, 1, 1, 0, 16'h8000, 6'h0);
        do_cycle();
        set_acc(0, 1, 0, 0, 16'h0000, 6'h0);
        do_cycle();
        set_acc(1, 0, 1, 0, 16'h0, 6'h0);
        #1 check("R6", hst_rdata & 16'h8000, 16'h8000);
        do_cycle();

        // R7: character plus error bits; R9: byte read
        rx_char0 = 8'hA5; rx_char1 = 8'h3C; rx_err0 = 4'b1010;
        set_acc(1, 0, 1, 1, 16'h0, 6'h0);
        #1 check("R7", hst_rdata, 16'h0AA5);
        do_cycle();
        set_acc(1, 0, 0, 1, 16'h0, 6'h0);
        #1 check("R9", hst_rdata, 16'h00A5);
        do_cycle();
        // R8: disable format, two characters
        set_acc(0, 1, 1, 0, 16'h0000, 6'h0);
        do_cycle();
        set_acc(1, 0, 1, 1, 16'h0, 6'h0);
        #1 check("R8", hst_rdata, 16'h3CA5);
        do_cycle();

        // R10: only one empty flag set
        txf_empty = 1; txsh_empty = 0;
        #1 check("R10", {15'd0, tx_drained}, 16'h0000);
        txsh_empty = 1;
        #1 check("R10", {15'd0, tx_drained}, 16'h0001);

        // Random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            {cts_in, dsr_in, cd_in, txf_empty, txsh_empty, rx_avail} = 6'($urandom);
            rx_char0 = 8'($urandom); rx_char1 = 8'($urandom); rx_err0 = 4'($urandom);
            set_acc(1'($urandom), ($urandom % 6) == 0, 1'($urandom), 1'($urandom),
                    16'($urandom), 6'($urandom & $urandom & $urandom));
            do_cycle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule